// File: doc/BRIEF.md
# Dual-Pattern Frame Sync Correlator

This block watches the chip stream of a Manchester receiver, one chip per strobe. It looks for a start-of-frame identifier built from two programmable patterns, A and B. Each pattern has its own length of up to 16 chips. A 2-bit mode picks how A and B combine, in one of four ways:

- A followed directly by B.
- Either pattern alone.
- A, then a chip gap of programmable length, then B.
- Either pattern, with the matching pattern reported as the first data bit.

When the identifier completes, the block raises a one-cycle frame-sync pulse together with the chip strobe that completed it. After that it stays locked until a restart. While locked it tracks the Manchester bit phase, which can optionally be re-aligned on chip sequences that mark a bit boundary. In gap mode it can also pulse a loop-reset output when the gap ends. The low four chip positions of pattern A can be masked as don't-care.

Top module: `fsync_corr`

## Requirements
- R1: After reset or `restart_i`, all outputs are low, the block is searching, and chips received before the restart take no part in any later match.
- R2: The chip on the current strobe is compared with pattern bit 0, and the chip received k strobes earlier is compared with bit k. A pattern of length L can match only once L chips have arrived since the last restart.
- R3: A length of 17 to 31 never matches. A length of 0 for A matches on every strobe in mode 00 and never matches in any other mode. A B length of 0 never matches.
- R4: Setting bit k of `wild_a_i` (k = 0..3) makes position k of pattern A always compare equal. Pattern B has no wildcard positions.
- R5: Mode 00 works as follows. After an A match, B is tested on the `len_b_i`-th following strobe. If B matches there, `fsync_o` pulses; otherwise the block returns to searching. When `len_b_i` is 0, the A match alone gives `fsync_o`.
- R6: In mode 01, a match of A or B on any strobe gives `fsync_o`.
- R7: Mode 11 behaves like mode 01, and `first_bit_vld_o` pulses with `fsync_o`. `first_bit_o` is 0 when A matched (including when both matched) and 1 when only B matched. `first_bit_o` is low whenever `first_bit_vld_o` is low.
- R8: Mode 10 works as follows. After an A match, the next `gap_len_i` strobes are ignored. B is then tested on each of the next max(`len_b_i`,1) strobes, and `fsync_o` pulses on the first hit. If none of those strobes hits, the block returns to searching.
- R9: `pll_rst_o` pulses only in mode 10 with `gap_resync_i` set. It pulses on the strobe that completes the gap, which is the A-match strobe itself when `gap_len_i` is 0.
- R10: `fsync_o` is high only during a chip strobe without restart. After it fires, it cannot fire again until `restart_i`. `restart_i` takes priority over a chip presented in the same cycle.
- R11: `manc_phase_o` is 0 before sync and 0 right after the sync strobe, and it toggles on each later strobe. With `manc_readj_i` set, a strobe that completes the chip sequence 1001 or 0110 (at least four chips since restart) forces it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_vld_i | input | 1 | Chip strobe |
| chip_i | input | 1 | Chip value, valid with the strobe |
| restart_i | input | 1 | Clear history and return to search |
| mode_i | input | 2 | 00 sequential, 01 either, 10 gap, 11 either with first bit |
| len_a_i | input | 5 | Pattern A length in chips |
| len_b_i | input | 5 | Pattern B length in chips |
| pat_a_i | input | 16 | Pattern A, bit 0 is the last chip |
| pat_b_i | input | 16 | Pattern B, bit 0 is the last chip |
| wild_a_i | input | 4 | Don't-care mask for A positions 0..3 |
| gap_len_i | input | 8 | Gap length in chips (mode 10) |
| gap_resync_i | input | 1 | Enable loop-reset pulse after the gap |
| manc_readj_i | input | 1 | Enable Manchester phase re-alignment |
| fsync_o | output | 1 | Frame-sync pulse |
| first_bit_vld_o | output | 1 | First data bit valid (mode 11) |
| first_bit_o | output | 1 | First data bit: 0 for A, 1 for B |
| pll_rst_o | output | 1 | Loop-reset pulse after the gap |
| manc_phase_o | output | 1 | 0 when the next chip starts a bit |

## Verification
The bench targets the following cases:

- **Stale history after a restart.** An all-zero pattern presented right after a restart must wait until enough chips have arrived. A design that forgot the fill count would sync on the first strobe.
- **Tie in mode 11.** When A and B are identical, the first bit must be 0. A wrong priority reports 1.
- **B window edges in sequential and gap modes.** Wrong counting shows up as a sync one strobe early or late, or as a failure to abort.
- **Zero and out-of-range lengths.** These must never sync where R3 forbids it.
- **Phase tracking.** Sequences containing 1001 and 0110, with re-alignment on and off, expose a re-alignment that fires when disabled or before four chips have arrived.

// File: rtl/fsync_corr_pkg.sv
package fsync_corr_pkg;
  typedef enum logic [1:0] {
    MODE_SEQ    = 2'b00,
    MODE_ANY    = 2'b01,
    MODE_GAP    = 2'b10,
    MODE_TAGGED = 2'b11
  } corr_mode_e;

  typedef enum logic [2:0] {
    ST_SRCH,
    ST_BSEQ,
    ST_GAP,
    ST_BWIN,
    ST_DONE
  } corr_state_e;

  localparam int unsigned WILD_N   = 4;
  localparam int unsigned N_PAT    = 2;
  localparam logic [3:0]  MANC_B01 = 4'b1001;
  localparam logic [3:0]  MANC_B10 = 4'b0110;
endpackage

// File: rtl/fsc_chip_hist.sv
module fsc_chip_hist #(
  parameter int MAX_CHIPS = 16,
  parameter int LEN_W     = $clog2(MAX_CHIPS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 shift_i,
  input  logic                 chip_i,
  output logic [MAX_CHIPS-1:0] win_o,
  output logic [LEN_W-1:0]     fill_o
);
  logic [MAX_CHIPS-1:0] hist_q;
  logic [LEN_W-1:0]     fill_q;

  // window already contains the chip on the current strobe
  assign win_o  = {hist_q[MAX_CHIPS-2:0], chip_i};
  assign fill_o = (int'(fill_q) >= MAX_CHIPS) ? fill_q : fill_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (clr_i) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (shift_i) begin
      hist_q <= win_o;
      fill_q <= fill_o;
    end
  end
endmodule

// File: rtl/fsc_pat_cmp.sv
module fsc_pat_cmp #(
  parameter int MAX_CHIPS = 16,
  parameter int LEN_W     = $clog2(MAX_CHIPS + 1)
) (
  input  logic [MAX_CHIPS-1:0] win_i,
  input  logic [MAX_CHIPS-1:0] pat_i,
  input  logic [MAX_CHIPS-1:0] mask_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic [LEN_W-1:0]     fill_i,
  input  logic                 zero_ok_i,
  output logic                 hit_o
);
  logic bits_ok;
  logic len_legal;
  logic filled;

  always_comb begin
    bits_ok = 1'b1;
    for (int i = 0; i < MAX_CHIPS; i++) begin
      if ((i < int'(len_i)) && !mask_i[i] && (win_i[i] != pat_i[i])) bits_ok = 1'b0;
    end
  end

  assign len_legal = int'(len_i) <= MAX_CHIPS;
  assign filled    = int'(fill_i) >= int'(len_i);
  assign hit_o     = len_legal && ((len_i == '0) ? zero_ok_i : (filled && bits_ok));
endmodule

// File: rtl/fsc_manc_phase.sv
module fsc_manc_phase
  import fsync_corr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       start_i,
  input  logic       step_i,
  input  logic       readj_i,
  input  logic       ready_i,
  input  logic [3:0] win4_i,
  output logic       phase_o
);
  logic phase_q;
  logic boundary;

  assign boundary = readj_i && ready_i && ((win4_i == MANC_B01) || (win4_i == MANC_B10));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= 1'b0;
    else if (clr_i)   phase_q <= 1'b0;
    else if (start_i) phase_q <= 1'b0;
    else if (step_i)  phase_q <= boundary ? 1'b0 : ~phase_q;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/fsync_corr.sv
module fsync_corr
  import fsync_corr_pkg::*;
#(
  parameter int MAX_CHIPS = 16,
  parameter int GAP_W     = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                chip_vld_i,
  input  logic                                chip_i,
  input  logic                                restart_i,
  input  logic [1:0]                          mode_i,
  input  logic [$clog2(MAX_CHIPS+1)-1:0]      len_a_i,
  input  logic [$clog2(MAX_CHIPS+1)-1:0]      len_b_i,
  input  logic [MAX_CHIPS-1:0]                pat_a_i,
  input  logic [MAX_CHIPS-1:0]                pat_b_i,
  input  logic [WILD_N-1:0]                   wild_a_i,
  input  logic [GAP_W-1:0]                    gap_len_i,
  input  logic                                gap_resync_i,
  input  logic                                manc_readj_i,
  output logic                                fsync_o,
  output logic                                first_bit_vld_o,
  output logic                                first_bit_o,
  output logic                                pll_rst_o,
  output logic                                manc_phase_o
);
  localparam int LEN_W = $clog2(MAX_CHIPS + 1);
  localparam int CNT_W = (GAP_W > LEN_W) ? GAP_W : LEN_W;

  corr_mode_e  mode;
  corr_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic b_last, gap_last;

  logic [MAX_CHIPS-1:0] win;
  logic [LEN_W-1:0]     fill;

  logic [N_PAT-1:0][MAX_CHIPS-1:0] pat_v, mask_v;
  logic [N_PAT-1:0][LEN_W-1:0]     len_v;
  logic [N_PAT-1:0]                zero_ok_v, hit_v;
  logic a_hit, b_hit;
  logic fsync, fbit, pll;

  assign mode = corr_mode_e'(mode_i);

  fsc_chip_hist #(.MAX_CHIPS(MAX_CHIPS), .LEN_W(LEN_W)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (restart_i),
    .shift_i (chip_vld_i),
    .chip_i  (chip_i),
    .win_o   (win),
    .fill_o  (fill)
  );

  assign pat_v     = {pat_b_i, pat_a_i};
  assign mask_v    = {{MAX_CHIPS{1'b0}}, {{(MAX_CHIPS-WILD_N){1'b0}}, wild_a_i}};
  assign len_v     = {len_b_i, len_a_i};
  assign zero_ok_v = {1'b0, (mode == MODE_SEQ)};

  for (genvar g = 0; g < N_PAT; g++) begin : g_cmp
    fsc_pat_cmp #(.MAX_CHIPS(MAX_CHIPS), .LEN_W(LEN_W)) u_cmp (
      .win_i     (win),
      .pat_i     (pat_v[g]),
      .mask_i    (mask_v[g]),
      .len_i     (len_v[g]),
      .fill_i    (fill),
      .zero_ok_i (zero_ok_v[g]),
      .hit_o     (hit_v[g])
    );
  end

  assign a_hit = hit_v[0];
  assign b_hit = hit_v[1];

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign b_last   = cnt_inc >= {{(CNT_W+1-LEN_W){1'b0}}, len_b_i};
  assign gap_last = cnt_inc == {{(CNT_W+1-GAP_W){1'b0}}, gap_len_i};

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    fsync = 1'b0;
    fbit  = 1'b0;
    pll   = 1'b0;
    if (restart_i) begin
      st_d  = ST_SRCH;
      cnt_d = '0;
    end else if (chip_vld_i) begin
      unique case (st_q)
        ST_SRCH: begin
          unique case (mode)
            MODE_SEQ: if (a_hit) begin
              if (len_b_i == '0) begin
                fsync = 1'b1;
                st_d  = ST_DONE;
              end else begin
                st_d  = ST_BSEQ;
                cnt_d = '0;
              end
            end
            MODE_ANY, MODE_TAGGED: if (a_hit || b_hit) begin
              fsync = 1'b1;
              fbit  = (mode == MODE_TAGGED) && !a_hit;  // A wins a tie
              st_d  = ST_DONE;
            end
            MODE_GAP: if (a_hit) begin
              cnt_d = '0;
              if (gap_len_i == '0) begin
                pll  = gap_resync_i;
                st_d = ST_BWIN;
              end else begin
                st_d = ST_GAP;
              end
            end
            default: ;
          endcase
        end
        ST_BSEQ: begin
          if (b_last) begin
            cnt_d = '0;
            if (b_hit) begin
              fsync = 1'b1;
              st_d  = ST_DONE;
            end else begin
              st_d = ST_SRCH;
            end
          end else begin
            cnt_d = cnt_inc[CNT_W-1:0];
          end
        end
        ST_GAP: begin
          if (gap_last) begin
            pll   = gap_resync_i;
            st_d  = ST_BWIN;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_inc[CNT_W-1:0];
          end
        end
        ST_BWIN: begin
          if (b_hit) begin
            fsync = 1'b1;
            st_d  = ST_DONE;
          end else if (b_last) begin
            st_d  = ST_SRCH;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_inc[CNT_W-1:0];
          end
        end
        ST_DONE: ;
        default: st_d = ST_SRCH;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_SRCH;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  fsc_manc_phase u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (restart_i),
    .start_i (fsync),
    .step_i  (chip_vld_i && (st_q == ST_DONE)),
    .readj_i (manc_readj_i),
    .ready_i (int'(fill) >= 4),
    .win4_i  (win[3:0]),
    .phase_o (manc_phase_o)
  );

  assign fsync_o         = fsync;
  assign first_bit_vld_o = fsync && (mode == MODE_TAGGED);
  assign first_bit_o     = fbit;
  assign pll_rst_o       = pll;
endmodule

// File: rtl/fsync_corr_chk.sv
module fsync_corr_chk #(
  parameter int MAX_CHIPS = 16,
  parameter int LEN_W     = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chip_vld_i,
  input logic             restart_i,
  input logic [1:0]       mode_i,
  input logic [LEN_W-1:0] len_a_i,
  input logic [LEN_W-1:0] len_b_i,
  input logic             gap_resync_i,
  input logic             fsync_o,
  input logic             first_bit_vld_o,
  input logic             first_bit_o,
  input logic             pll_rst_o,
  input logic             manc_phase_o
);
  logic synced_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        synced_q <= 1'b0;
    else if (restart_i) synced_q <= 1'b0;
    else if (fsync_o)   synced_q <= 1'b1;
  end

  p_fsync_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |-> (chip_vld_i && !restart_i));

  p_one_sync_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    synced_q |-> !fsync_o);

  p_first_bit_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_bit_vld_o |-> (fsync_o && (mode_i == 2'b11)));

  p_first_bit_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !first_bit_vld_o |-> !first_bit_o);

  p_pll_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_rst_o |-> ((mode_i == 2'b10) && gap_resync_i && chip_vld_i && !restart_i));

  p_bad_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[0] && (int'(len_a_i) > MAX_CHIPS) && (int'(len_b_i) > MAX_CHIPS)) |-> !fsync_o);

  p_phase_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !synced_q |-> !manc_phase_o);

  p_restart_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!manc_phase_o && !synced_q));
endmodule

bind fsync_corr fsync_corr_chk #(.MAX_CHIPS(MAX_CHIPS), .LEN_W(LEN_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .chip_vld_i      (chip_vld_i),
  .restart_i       (restart_i),
  .mode_i          (mode_i),
  .len_a_i         (len_a_i),
  .len_b_i         (len_b_i),
  .gap_resync_i    (gap_resync_i),
  .fsync_o         (fsync_o),
  .first_bit_vld_o (first_bit_vld_o),
  .first_bit_o     (first_bit_o),
  .pll_rst_o       (pll_rst_o),
  .manc_phase_o    (manc_phase_o)
);

// File: tb/fsync_corr_tb.sv
module fsync_corr_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chip_vld, chip, restart;
  logic [1:0]  mode;
  logic [4:0]  len_a, len_b;
  logic [15:0] pat_a, pat_b;
  logic [3:0]  wild;
  logic [7:0]  gap_len;
  logic        gap_resync, readj;
  logic        fsync, fbv, fb, pll, phase;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    finished = 0;
  string cur_req = "R1";

  int m_hist[$];
  int m_st, m_cnt;
  bit m_phase;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsync_corr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .chip_vld_i(chip_vld), .chip_i(chip), .restart_i(restart),
    .mode_i(mode), .len_a_i(len_a), .len_b_i(len_b), .pat_a_i(pat_a), .pat_b_i(pat_b),
    .wild_a_i(wild), .gap_len_i(gap_len), .gap_resync_i(gap_resync), .manc_readj_i(readj),
    .fsync_o(fsync), .first_bit_vld_o(fbv), .first_bit_o(fb), .pll_rst_o(pll),
    .manc_phase_o(phase)
  );

  function automatic bit m_hit(input logic [15:0] pat, input int len, input logic [15:0] msk,
                               input bit zero_ok);
    if (len > 16) return 0;
    if (len == 0) return zero_ok;
    if (m_hist.size() < len) return 0;
    for (int i = 0; i < len; i++)
      if (!msk[i] && (m_hist[i] != int'(pat[i]))) return 0;
    return 1;
  endfunction

  task automatic compare(input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t {fsync,fbv,fb,pll,phase} actual=%b expected=%b",
               cur_req, $time, act, exp);
    end
  endtask

  task automatic model_cycle(input bit vld, input bit ch, input bit rs);
    bit e_fs, e_fbv, e_fb, e_pll, nxt_ph, a, b;
    int md, lb, w;
    e_fs = 0; e_fbv = 0; e_fb = 0; e_pll = 0; nxt_ph = m_phase;
    md = int'(mode); lb = int'(len_b);
    if (rs) begin
      m_hist.delete(); m_st = 0; m_cnt = 0; nxt_ph = 0;
    end else if (vld) begin
      m_hist.push_front(int'(ch));
      if (m_hist.size() > 16) void'(m_hist.pop_back());
      a = m_hit(pat_a, int'(len_a), {12'b0, wild}, md == 0);
      b = m_hit(pat_b, lb, 16'b0, 0);
      case (m_st)
        0: begin
          if (md == 0 && a) begin
            if (lb == 0) begin e_fs = 1; m_st = 4; nxt_ph = 0; end
            else begin m_st = 1; m_cnt = 0; end
          end else if ((md == 1 || md == 3) && (a || b)) begin
            e_fs = 1; m_st = 4; nxt_ph = 0;
            if (md == 3) begin e_fbv = 1; e_fb = !a; end
          end else if (md == 2 && a) begin
            m_cnt = 0;
            if (gap_len == 0) begin e_pll = gap_resync; m_st = 3; end
            else m_st = 2;
          end
        end
        1: begin
          m_cnt++;
          if (m_cnt == lb) begin
            m_cnt = 0;
            if (b) begin e_fs = 1; m_st = 4; nxt_ph = 0; end
            else m_st = 0;
          end
        end
        2: begin
          m_cnt++;
          if (m_cnt == int'(gap_len)) begin e_pll = gap_resync; m_st = 3; m_cnt = 0; end
        end
        3: begin
          w = (lb == 0) ? 1 : lb;
          if (b) begin e_fs = 1; m_st = 4; nxt_ph = 0; end
          else begin
            m_cnt++;
            if (m_cnt >= w) begin m_st = 0; m_cnt = 0; end
          end
        end
        default: begin
          if (readj && m_hist.size() >= 4 &&
              m_hist[3] == m_hist[0] && m_hist[2] == m_hist[1] && m_hist[0] != m_hist[1])
            nxt_ph = 0;
          else
            nxt_ph = !m_phase;
        end
      endcase
    end
    compare({fsync, fbv, fb, pll, phase}, {e_fs, e_fbv, e_fb, e_pll, m_phase});
    m_phase = nxt_ph;
  endtask

  task automatic tick(input bit vld, input bit ch, input bit rs);
    chip_vld = vld; chip = ch; restart = rs;
    @(negedge clk);
    model_cycle(vld, ch, rs);
    @(posedge clk);
    #1;
    chip_vld = 0; restart = 0;
  endtask

  task automatic send(input logic [15:0] bits, input int n, input int spacing);
    for (int k = n - 1; k >= 0; k--) begin
      tick(1, bits[k], 0);
      for (int s = 0; s < spacing; s++) tick(0, 0, 0);
    end
  endtask

  task automatic send_rand(input int n);
    for (int k = 0; k < n; k++) begin
      tick(1, 1'($urandom), 0);
      if ($urandom % 3 == 0) tick(0, 0, 0);
    end
  endtask

  task automatic rst_cfg(input int md);
    mode = 2'(md);
    tick(0, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; chip_vld = 0; chip = 0; restart = 0;
    mode = 2'b01; len_a = 8; len_b = 8; pat_a = 16'h00B4; pat_b = 16'h00E2;
    wild = 0; gap_len = 3; gap_resync = 1; readj = 0;
    m_st = 0; m_cnt = 0; m_phase = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_req = "R1";
    compare({fsync, fbv, fb, pll, phase}, 5'b0);  // R1 reset state
    @(posedge clk); #1;
    rst_n = 1;

    cur_req = "R6";  // either pattern syncs
    rst_cfg(1); send(16'h0013, 5, 0); send(pat_a, 8, 1); send_rand(6);
    rst_cfg(1); send(16'h0005, 3, 0); send(pat_b, 8, 0);

    cur_req = "R10";  // locked after sync, restart beats a chip
    send(pat_a, 8, 0); send(pat_b, 8, 0);
    tick(1, 1, 1); send(pat_a, 8, 0);

    cur_req = "R7";  // tagged mode, tie goes to A
    rst_cfg(3); send(pat_a, 8, 0);
    rst_cfg(3); send(pat_b, 8, 1);
    pat_b = pat_a; rst_cfg(3); send(pat_a, 8, 0);
    pat_b = 16'h00E2;

    cur_req = "R5";  // A then B back to back
    len_a = 6; pat_a = 16'h0032; len_b = 4; pat_b = 16'h000B;
    rst_cfg(0); send(pat_a, 6, 0); send(pat_b, 4, 0);
    rst_cfg(0); send(pat_a, 6, 0); send(16'h0009, 4, 1); send(pat_a, 6, 0); send(pat_b, 4, 0);
    len_b = 0; rst_cfg(0); send(16'h0001, 2, 0); send(pat_a, 6, 0);

    cur_req = "R3";  // zero and out-of-range lengths
    len_a = 0; len_b = 0; rst_cfg(0); tick(1, 0, 0); tick(1, 1, 0);
    len_b = 20; rst_cfg(1); send_rand(40);
    len_a = 17; len_b = 4; pat_b = 16'h000F; rst_cfg(1); send(16'h0000, 8, 0); send(16'h000F, 4, 0);
    len_a = 8; len_b = 0; rst_cfg(2); send(pat_a, 8, 0); send_rand(6);

    cur_req = "R2";  // needs len chips since restart
    len_a = 4; pat_a = 16'h0000; len_b = 4; pat_b = 16'h000F;
    rst_cfg(1); send(16'h0000, 4, 2);
    rst_cfg(1); send(16'h0007, 3, 0); send(16'h0001, 1, 0);

    cur_req = "R4";  // wildcard on A only
    len_a = 8; pat_a = 16'h00B4; len_b = 8; pat_b = 16'h00E2; wild = 4'b0101;
    rst_cfg(1); send(16'h00B1, 8, 0);
    rst_cfg(1); send(16'h00E3, 8, 0); send(16'h00B0, 8, 0);
    wild = 0; rst_cfg(1); send(16'h00B1, 8, 0);

    cur_req = "R8";  // gap sequence
    len_a = 6; pat_a = 16'h0032; len_b = 4; pat_b = 16'h000B; gap_len = 3; gap_resync = 1;
    rst_cfg(2); send(pat_a, 6, 0); send(16'h0005, 3, 0); send(pat_b, 4, 0);
    rst_cfg(2); send(pat_a, 6, 0); send(16'h0000, 3, 0); send(16'h0000, 4, 1);
    send(pat_a, 6, 0); send(16'h0007, 3, 0); send(16'h0001, 2, 0); send(pat_b, 4, 0);
    cur_req = "R9";  // loop reset pulse
    gap_len = 0; rst_cfg(2); send(pat_a, 6, 0); send(pat_b, 4, 0);
    gap_resync = 0; gap_len = 2; rst_cfg(2); send(pat_a, 6, 0); send(16'h0001, 2, 0); send(pat_b, 4, 0);

    cur_req = "R11";  // phase tracking
    len_a = 8; pat_a = 16'h00B4; readj = 0;
    rst_cfg(1); send(pat_a, 8, 0); send(16'h9669, 16, 0);
    readj = 1; rst_cfg(1); send(pat_a, 8, 0); send(16'h9669, 16, 1); send_rand(20);
    len_a = 0; len_b = 0; rst_cfg(0); send(16'h0006, 4, 0);

    cur_req = "R10";  // random traffic in all modes
    for (int t = 0; t < 60; t++) begin
      int ra, rb;
      ra = 1 + ($urandom % 16); rb = $urandom % 17;
      len_a = 5'(ra); len_b = 5'(rb);
      pat_a = 16'($urandom); pat_b = 16'($urandom);
      wild = 4'($urandom); gap_len = 8'($urandom % 5);
      gap_resync = 1'($urandom); readj = 1'($urandom);
      rst_cfg(int'($urandom % 4));
      send_rand(int'($urandom % 6));
      send(pat_a, ra, 0);
      send_rand(int'(gap_len));
      send(pat_b, rb, 0);
      send_rand(20);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule